// File: doc/BRIEF.md
# Video Memory Data Port with Palette

This block is the processor-facing window into the memory of a tile-based video controller. The processor sets a 14-bit video address with two byte writes to an address register. It then moves bytes through a data register. Each data access steps the address by one.

Ordinary video memory is held outside the block. It is reached over a simple nametable interface that ignores address bit 12. A read from that memory comes back one access late through a read buffer.

The top page of the address space, $3F00-$3FFF, is served by a small palette store inside the block. A read in that page returns the palette entry at once. In the same access, the read buffer takes the nametable byte hidden beneath the palette page. Palette writes never reach the nametable memory.

Top module: `vmem_port`

## Requirements
- R1: The first address-register write (select 1) sets address bits 13:8 from bits 5:0 of the byte, and the upper two bits are dropped. The second write sets bits 7:0. The writes then keep alternating high, low.
- R2: A read of the status register (select 0) makes the next address-register write a high-byte write, even after only one byte has been written.
- R3: A data-register read (select 2) at an address below $3F00 returns the current buffer byte. In the same access, the buffer reloads from the nametable byte at that address.
- R4: A data read at $3F00-$3FFF returns the palette entry in the same access, with the 6-bit entry in bits 5:0 and zeros in bits 7:6.
- R5: A palette-page read loads the buffer with the nametable byte at the address with bit 12 cleared, never with the palette value. For example: write $9A at $2F12, read once, read at $3F12, then read at $2F13. That last read returns $9A.
- R6: A data write at $3F00-$3FFF updates only the palette and never asserts nt_we.
- R7: nt_addr always carries the video address with bit 12 forced to zero, so $3000-$3EFF aliases $2000-$2EFF.
- R8: The palette holds 32 six-bit entries that repeat every 32 bytes across $3F00-$3FFF. Entries $10, $14, $18 and $1C share storage with $00, $04, $08 and $0C for both reads and writes.
- R9: Every data read or write raises the video address by 1, wrapping from $3FFF to $0000.
- R10: After reset, the video address and the read buffer are zero, and the next address write is a high-byte write.
- R11: A data write below $3F00 asserts nt_we in that cycle, with nt_wdata equal to the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 2 | Register select: 0 status, 1 address, 2 data |
| cpu_wdata | input | 8 | Write byte |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rdata | output | 8 | Read byte, valid during the read strobe |
| nt_addr | output | 14 | Nametable address, bit 12 forced to zero |
| nt_wdata | output | 8 | Nametable write byte |
| nt_we | output | 1 | Nametable write enable |
| nt_rdata | input | 8 | Nametable read byte, combinational from nt_addr |

## Verification
A wrong address register shows on nt_addr in the cycle after the faulty write or step, so it is caught at the next sample. A stale or wrongly sourced read buffer stays hidden until the next ordinary data read, which then returns the wrong byte. The hidden-nametable sequence and mixed random traffic are aimed at exactly that one-access lag. A broken palette mirror shows only when the partner entry is read, so the random traffic concentrates its addresses in the palette page and in the $2Fxx page beneath it.

// File: rtl/vmem_port.sv
module vmem_port #(
  parameter int VA_W  = 14,
  parameter int PAL_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cpu_sel,
  input  logic [7:0]      cpu_wdata,
  input  logic            cpu_rd,
  input  logic            cpu_wr,
  output logic [7:0]      cpu_rdata,
  output logic [VA_W-1:0] nt_addr,
  output logic [7:0]      nt_wdata,
  output logic            nt_we,
  input  logic [7:0]      nt_rdata
);
  localparam int PAL_N = 32;
  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [VA_W-1:0] ALIAS_MASK = ~(VA_W'(1) << 12);

  logic [VA_W-1:0]  vaddr;
  logic             hi_next;
  logic [7:0]       rbuf;
  logic [PAL_W-1:0] pal [PAL_N];

  wire stat_rd = cpu_rd && (cpu_sel == SEL_STAT);
  wire addr_wr = cpu_wr && (cpu_sel == SEL_ADDR);
  wire data_rd = cpu_rd && (cpu_sel == SEL_DATA);
  wire data_wr = cpu_wr && (cpu_sel == SEL_DATA);

  wire       in_pal  = &vaddr[VA_W-1:8];
  wire [4:0] pal_idx = {vaddr[4] & (vaddr[1:0] != 2'b00), vaddr[3:0]};

  assign nt_addr  = vaddr & ALIAS_MASK;
  assign nt_wdata = cpu_wdata;
  assign nt_we    = data_wr && !in_pal;

  always_comb begin
    cpu_rdata = 8'h00;
    if (cpu_sel == SEL_DATA)
      cpu_rdata = in_pal ? {{(8-PAL_W){1'b0}}, pal[pal_idx]} : rbuf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaddr   <= '0;
      hi_next <= 1'b1;
      rbuf    <= 8'h00;
      for (int i = 0; i < PAL_N; i++) pal[i] <= '0;
    end else begin
      if (stat_rd) hi_next <= 1'b1;
      if (addr_wr) begin
        if (hi_next) vaddr[VA_W-1:8] <= cpu_wdata[VA_W-9:0];
        else         vaddr[7:0]      <= cpu_wdata;
        hi_next <= !hi_next;
      end
      if (data_rd || data_wr) vaddr <= vaddr + 1'b1;
      if (data_rd) rbuf <= nt_rdata;
      if (data_wr && in_pal) pal[pal_idx] <= cpu_wdata[PAL_W-1:0];
    end
  end
endmodule

module vmem_port_chk #(
  parameter int VA_W = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cpu_sel,
  input logic [7:0]      cpu_wdata,
  input logic            cpu_rd,
  input logic            cpu_wr,
  input logic [7:0]      cpu_rdata,
  input logic            nt_we,
  input logic [7:0]      nt_wdata,
  input logic [7:0]      nt_rdata,
  input logic [VA_W-1:0] vaddr
);
  wire drd = cpu_rd && cpu_sel == 2'd2;
  wire dwr = cpu_wr && cpu_sel == 2'd2;
  wire pal_pg = vaddr[VA_W-1:8] == {(VA_W-8){1'b1}};
  logic [7:0] shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) shadow <= 8'h00;
    else if (drd) shadow <= nt_rdata;
  end

  // R3
  delayed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drd && !pal_pg |-> cpu_rdata == shadow);
  // R4
  pal_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drd && pal_pg |-> cpu_rdata[7:6] == 2'b00);
  // R6
  pal_write_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && pal_pg |-> !nt_we);
  // R9
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drd || dwr) |=> vaddr == $past(vaddr) + 1'b1);
  // R11
  nt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && !pal_pg |-> nt_we && nt_wdata == cpu_wdata);
endmodule

bind vmem_port vmem_port_chk #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .nt_we(nt_we),
  .nt_wdata(nt_wdata), .nt_rdata(nt_rdata), .vaddr(vaddr)
);

// File: tb/vmem_port_bench.sv
module vmem_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cpu_sel = 2'd0;
  logic [7:0] cpu_wdata = 8'h00;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_rdata, nt_wdata, nt_rdata;
  logic [13:0] nt_addr;
  logic nt_we;

  int checks = 0, errors = 0;
  logic [7:0] mem [16384];
  logic [7:0] rnt [16384];
  logic [5:0] rp [32];
  logic [13:0] va;
  logic [7:0] rb;

  always #4 clk = ~clk;

  vmem_port u_vmem_port (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .nt_addr(nt_addr),
    .nt_wdata(nt_wdata), .nt_we(nt_we), .nt_rdata(nt_rdata)
  );

  assign nt_rdata = mem[nt_addr];
  always_ff @(posedge clk) if (nt_we) mem[nt_addr] <= nt_wdata;

  function automatic logic is_pal(logic [13:0] a);
    return a[13:8] == 6'h3F;
  endfunction
  function automatic logic [4:0] pidx(logic [13:0] a);
    return {a[4] & (a[1:0] != 2'b00), a[3:0]};
  endfunction
  function automatic logic [13:0] ntm(logic [13:0] a);
    return a & 14'h2FFF;
  endfunction

  task automatic check(string req, logic [13:0] act, logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] s, logic [7:0] d);
    @(negedge clk); cpu_sel = s; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask
  task automatic rd_reg(logic [1:0] s, output logic [7:0] d);
    @(negedge clk); cpu_sel = s; cpu_rd = 1'b1;
    #2 d = cpu_rdata;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic set_addr(logic [7:0] hi, logic [7:0] lo);
    wr_reg(2'd1, hi); wr_reg(2'd1, lo);
    va = {hi[5:0], lo};
  endtask
  task automatic data_wr(logic [7:0] d);
    wr_reg(2'd2, d);
    if (is_pal(va)) rp[pidx(va)] = d[5:0];
    else rnt[ntm(va)] = d;
    va = va + 14'd1;
  endtask
  task automatic data_rd(string req, output logic [7:0] got);
    logic [7:0] exp;
    rd_reg(2'd2, got);
    exp = is_pal(va) ? {2'b00, rp[pidx(va)]} : rb;
    rb = rnt[ntm(va)];
    va = va + 14'd1;
    check(req, {6'd0, got}, {6'd0, exp});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int seed;
    seed = 7;
    for (int i = 0; i < 16384; i++) begin mem[i] = 8'h00; rnt[i] = 8'h00; end
    for (int i = 0; i < 32; i++) rp[i] = 6'h00;
    va = 14'h0; rb = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10", nt_addr, 14'h0000);
    data_rd("R10", d);
    check("R10", nt_addr, 14'h0001);
    // R1 high byte keeps low 6 bits
    set_addr(8'hC5, 8'h34);
    #1 check("R1", nt_addr, 14'h0534);
    // R2 status read resets toggle
    wr_reg(2'd1, 8'h11);
    rd_reg(2'd0, d);
    set_addr(8'h07, 8'h08);
    #1 check("R2", nt_addr, 14'h0708);
    // R11 / R7 nametable write at 3456 aliases 2456
    set_addr(8'h34, 8'h56);
    #1 check("R7", nt_addr, 14'h2456);
    data_wr(8'h77);
    set_addr(8'h24, 8'h56);
    data_rd("R3", d);
    data_rd("R11", d);
    check("R11", {6'd0, d}, 14'h0077);
    // R5 hidden nametable sequence
    set_addr(8'h2F, 8'h12);
    data_wr(8'h9A);
    data_rd("R3", d);
    set_addr(8'hFF, 8'h12);
    data_rd("R4", d);
    set_addr(8'h2F, 8'h13);
    data_rd("R5", d);
    check("R5", {6'd0, d}, 14'h009A);
    // R4 upper bits zero
    set_addr(8'h3F, 8'h05);
    data_wr(8'hFF);
    set_addr(8'h3F, 8'h05);
    data_rd("R4", d);
    check("R4", {6'd0, d}, 14'h003F);
    // R6 palette write leaves nametable untouched
    set_addr(8'h3F, 8'h07);
    data_wr(8'h11);
    set_addr(8'h2F, 8'h07);
    data_rd("R6", d);
    data_rd("R6", d);
    check("R6", {6'd0, d}, 14'h0000);
    // R8 transparent mirror and 32-entry repeat
    set_addr(8'h3F, 8'h10);
    data_wr(8'h2A);
    set_addr(8'h3F, 8'h00);
    data_rd("R8", d);
    check("R8", {6'd0, d}, 14'h002A);
    set_addr(8'h3F, 8'hE7);
    data_rd("R8", d);
    check("R8", {6'd0, d}, 14'h0011);
    // R9 wrap
    set_addr(8'h3F, 8'hFF);
    data_rd("R9", d);
    #1 check("R9", nt_addr, 14'h0000);

    rd_reg(2'd0, d);
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = (n == 0) ? int'($urandom(seed) % 4) : int'($urandom % 4);
      if (op == 0) begin
        logic [7:0] hi;
        case ($urandom % 4)
          0: hi = 8'h3F;
          1: hi = 8'h2F;
          2: hi = 8'h3F;
          default: hi = 8'($urandom);
        endcase
        set_addr(hi, 8'($urandom % 48));
        #1 check("R1", nt_addr, ntm(va));
      end else if (op == 1) begin
        data_wr(8'($urandom));
        #1 check("R9", nt_addr, ntm(va));
      end else begin
        data_rd(is_pal(va) ? "R8" : "R3", d);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule